// File: doc/BRIEF.md
# Interrupt Latch and Vectoring Controller

This block collects interrupt requests into a 32-bit latch register and decides which one the core vectors to next. Hardware request lines set latch bits. Software sets the upper four bits, either through a bit-set port that ORs a pattern into the latch or through a full write that replaces the whole register. Each latched bit is gated by its mask bit and by a global enable. The lowest-numbered surviving bit wins. The controller then issues a one-cycle vector pulse with that bit's index and a one-hot acknowledge. In the same cycle it clears the latch bit and marks the routine as active.

Active routines are held in an active register. A return-from-interrupt strobe retires the lowest-numbered active bit. When nesting is enabled, an active routine blocks only its own bit and every higher-numbered bit, so a more urgent request can still preempt it. When nesting is disabled, any active routine blocks all requests. A registered temporary mask (the mask with the blocked bits cleared) is kept up to date in both modes.

A two-state machine tracks whether any routine is active:
- ST_IDLE means no routine is active.
- ST_SERVE means at least one routine is active.

It has three transitions:
- "take" moves ST_IDLE to ST_SERVE.
- "last return" moves ST_SERVE to ST_IDLE. This happens on a return strobe while exactly one active bit remains.
- "stay" keeps the current state in every other case.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A 1 on any bit of `irq_in` sets the matching latch bit at the next clock edge. Latch bits already set stay set. The latch is visible on `latch_o`.
- R2: Software bits 28 to 31 (and any other bit) can be raised in two ways. `lat_set_en` ORs `lat_set_data` into the latch. `lat_wr_en` replaces the latch with `lat_wr_data`. Hardware and bit-set requests in the same cycle are ORed on top of a full write.
- R3: A latched bit can only be taken while its bit in `mask_in` is 1 and `glob_en` is 1.
- R4: Among the eligible bits, the lowest-numbered bit wins. The cycle after the decision edge, `vec_valid` is 1 for one cycle, `vec_idx` holds the winning bit number, and `vec_ack` is one-hot on that bit. At all other times `vec_ack` is 0.
- R5: Taking a bit clears that latch bit and sets the matching bit of `active_o`, both at the decision edge.
- R6: With `nest_en`=1, an active routine with index a blocks every latched bit numbered a or higher. Lower-numbered bits are still taken.
- R7: With `nest_en`=0, no vector is issued while any routine is active.
- R8: A request for a routine that is currently active stays set in the latch. It is taken only after the return that retires that routine.
- R9: A `rti` pulse clears the lowest-numbered set bit of `active_o`. No vector is decided in a cycle with `rti`=1. A `rti` with nothing active changes nothing.
- R10: `pmask_o` is registered. It equals `mask_in` with every bit at or above the lowest-numbered active bit cleared, computed from the active state after the same edge. It is updated whether nesting is enabled or disabled, and equals `mask_in` when nothing is active.
- R11: While `rst_n` is 0, `latch_o`, `active_o`, `pmask_o`, `vec_valid`, `vec_idx` and `vec_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Hardware request pulses, one per latch bit |
| mask_in | input | 32 | Per-bit enable; 1 allows the bit |
| glob_en | input | 1 | Global interrupt enable |
| nest_en | input | 1 | 1 allows higher-priority preemption |
| lat_wr_en | input | 1 | Replace latch with lat_wr_data |
| lat_wr_data | input | 32 | Full latch write value |
| lat_set_en | input | 1 | OR lat_set_data into latch |
| lat_set_data | input | 32 | Bit-set pattern |
| rti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | One-cycle vector request |
| vec_idx | output | 5 | Index of the taken bit |
| vec_ack | output | 32 | One-hot acknowledge of the cleared latch bit |
| latch_o | output | 32 | Current latch register |
| active_o | output | 32 | Routines in service |
| pmask_o | output | 32 | Temporary nested mask |

## Verification
On every cycle, the embedded properties check several things:
- The acknowledge is one-hot exactly when a vector is issued.
- No vector follows a return cycle.
- A vector only follows a cycle in which its mask bit and the global enable were set.
- With nesting enabled, no active routine sits at or below the taken index.
- With nesting disabled, nothing was active before a take.
- A bit-set always lands in the latch.
- A return retires exactly one active routine.

Only the bench scenarios can show the actual choice of winner, the latch contents after mixed write, set and hardware traffic, the delayed re-take of a request whose routine was running, and the exact values of the temporary mask.

// File: rtl/irq_pkg.sv
package irq_pkg;

    parameter int NUM_IRQ = 32;
    localparam int IDX_W  = $clog2(NUM_IRQ);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } svc_state_t;

    // bit i set when any bit 0..i of v is set
    function automatic logic [NUM_IRQ-1:0] prefix_or(input logic [NUM_IRQ-1:0] v);
        logic [NUM_IRQ-1:0] r;
        r[0] = v[0];
        for (int i = 1; i < NUM_IRQ; i++) begin
            r[i] = r[i-1] | v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N   = 32,
    parameter int IW  = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    logic [N-1:0] below;

    assign below[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign below[g] = below[g-1] | req[g-1];
        end
        for (g = 0; g < N; g++) begin : g_oh
            assign onehot[g] = req[g] & ~below[g];
        end
    endgenerate

    assign found = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_latch_reg.sv
module irq_latch_reg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_req,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    input  logic         set_en,
    input  logic [N-1:0] set_data,
    input  logic [N-1:0] clr_oh,
    output logic [N-1:0] latch_q
);
    logic [N-1:0] base;
    logic [N-1:0] latch_d;

    always_comb begin
        base    = wr_en ? wr_data : latch_q;
        latch_d = (base & ~clr_oh) | hw_req | (set_en ? set_data : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    // R2: a bit-set pattern is always present in the latch afterwards
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((latch_q & $past(set_data)) == $past(set_data)));

endmodule

// File: rtl/irq_active_trk.sv
module irq_active_trk #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [N-1:0] take_oh,
    input  logic         rti,
    output logic [N-1:0] active_q,
    output logic [N-1:0] active_d,
    output logic         single
);
    logic [N-1:0] lowest_oh;

    always_comb begin
        lowest_oh = active_q & (~active_q + N'(1));
        active_d  = active_q;
        if (rti) begin
            active_d = active_q & ~lowest_oh;
        end else if (take) begin
            active_d = active_q | take_oh;
        end
    end

    assign single = (active_q != '0) && (lowest_oh == active_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else begin
            active_q <= active_d;
        end
    end

    // R9: a return retires exactly one routine when any is active
    p_rti_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rti |=> ($countones(active_q) ==
                 $countones($past(active_q)) - (($past(active_q) != '0) ? 1 : 0)));

    // R5: the taken routine is marked active
    p_take_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rti) |=> ((active_q & $past(take_oh)) != '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int N  = NUM_IRQ,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic [N-1:0]  mask_in,
    input  logic          glob_en,
    input  logic          nest_en,
    input  logic          lat_wr_en,
    input  logic [N-1:0]  lat_wr_data,
    input  logic          lat_set_en,
    input  logic [N-1:0]  lat_set_data,
    input  logic          rti,
    output logic          vec_valid,
    output logic [IW-1:0] vec_idx,
    output logic [N-1:0]  vec_ack,
    output logic [N-1:0]  latch_o,
    output logic [N-1:0]  active_o,
    output logic [N-1:0]  pmask_o
);
    svc_state_t state_q, state_d;

    logic [N-1:0]  latch_q;
    logic [N-1:0]  active_q;
    logic [N-1:0]  active_d;
    logic          single_act;
    logic [N-1:0]  blk;
    logic [N-1:0]  cand;
    logic          cand_found;
    logic [IW-1:0] cand_idx;
    logic [N-1:0]  cand_oh;
    logic          take;
    logic [N-1:0]  clr_oh;

    logic          vec_valid_q;
    logic [IW-1:0] vec_idx_q;
    logic [N-1:0]  vec_ack_q;
    logic [N-1:0]  pmask_q;

    irq_latch_reg #(.N(N)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_req   (irq_in),
        .wr_en    (lat_wr_en),
        .wr_data  (lat_wr_data),
        .set_en   (lat_set_en),
        .set_data (lat_set_data),
        .clr_oh   (clr_oh),
        .latch_q  (latch_q)
    );

    irq_active_trk #(.N(N)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_oh  (cand_oh),
        .rti      (rti),
        .active_q (active_q),
        .active_d (active_d),
        .single   (single_act)
    );

    irq_prio_enc #(.N(N), .IW(IW)) u_enc (
        .req    (cand),
        .found  (cand_found),
        .idx    (cand_idx),
        .onehot (cand_oh)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and decision outputs
    always_comb begin
        state_d = state_q;
        blk     = prefix_or(active_q);
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = ST_SERVE;
                end
            end
            ST_SERVE: begin
                if (!nest_en) begin
                    blk = '1;
                end
                if (rti && single_act) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cand   = latch_q & mask_in & ~blk & {N{glob_en}};
    assign take   = cand_found & ~rti;
    assign clr_oh = take ? cand_oh : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_q <= 1'b0;
            vec_idx_q   <= '0;
            vec_ack_q   <= '0;
            pmask_q     <= '0;
        end else begin
            vec_valid_q <= take;
            vec_idx_q   <= take ? cand_idx : '0;
            vec_ack_q   <= clr_oh;
            pmask_q     <= mask_in & ~prefix_or(active_d);
        end
    end

    assign vec_valid = vec_valid_q;
    assign vec_idx   = vec_idx_q;
    assign vec_ack   = vec_ack_q;
    assign latch_o   = latch_q;
    assign active_o  = active_q;
    assign pmask_o   = pmask_q;

    // R4: acknowledge is one-hot exactly with a vector
    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($countones(vec_ack) == 1));
    p_ack_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_ack == '0));
    // R9: no vector decided in a return cycle
    p_no_vec_on_rti_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !$past(rti));
    // R3: mask bit and global enable were set
    p_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(glob_en) && (($past(mask_in) & vec_ack) != '0)));
    // R6: nothing active at or below the taken index when nesting
    p_nest_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(nest_en)) |->
            (($past(active_o) & (vec_ack | (vec_ack - N'(1)))) == '0));
    // R7: nesting off means nothing was active before a take
    p_nest_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !$past(nest_en)) |-> ($past(active_o) == '0));

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  mask_in = '1;
    logic          glob_en = 1'b1;
    logic          nest_en = 1'b1;
    logic          lat_wr_en = 1'b0;
    logic [N-1:0]  lat_wr_data = '0;
    logic          lat_set_en = 1'b0;
    logic [N-1:0]  lat_set_data = '0;
    logic          rti = 1'b0;
    logic          vec_valid;
    logic [4:0]    vec_idx;
    logic [N-1:0]  vec_ack;
    logic [N-1:0]  latch_o;
    logic [N-1:0]  active_o;
    logic [N-1:0]  pmask_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .mask_in      (mask_in),
        .glob_en      (glob_en),
        .nest_en      (nest_en),
        .lat_wr_en    (lat_wr_en),
        .lat_wr_data  (lat_wr_data),
        .lat_set_en   (lat_set_en),
        .lat_set_data (lat_set_data),
        .rti          (rti),
        .vec_valid    (vec_valid),
        .vec_idx      (vec_idx),
        .vec_ack      (vec_ack),
        .latch_o      (latch_o),
        .active_o     (active_o),
        .pmask_o      (pmask_o)
    );

    typedef struct packed {
        logic [31:0] hw;
        logic [31:0] setd;
        logic        wr;
        logic [31:0] wrd;
        logic [31:0] msk;
        logic        ge;
        logic        ne;
        logic        rt;
        logic        ev;
        logic [4:0]  ei;
        logic [31:0] elat;
        logic [31:0] eact;
    } row_t;

    localparam int ROWS = 24;
    localparam logic [31:0] F = 32'hFFFF_FFFF;
    localparam row_t TBL [ROWS] = '{
        '{32'h20,  0, 0, 0, F, 1, 1, 0, 0, 0,  32'h20,  32'h0},   // R1 latch
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 1, 5,  32'h0,   32'h20},  // R4 R5 take 5
        '{32'h228, 0, 0, 0, F, 1, 1, 0, 0, 0,  32'h228, 32'h20},  // R1 R8
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 1, 3,  32'h220, 32'h28},  // R6 preempt 3
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 0, 0,  32'h220, 32'h28},  // R6 blocked
        '{32'h0,   0, 0, 0, F, 1, 1, 1, 0, 0,  32'h220, 32'h20},  // R9 pop 3
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 0, 0,  32'h220, 32'h20},  // R8 own bit held
        '{32'h0,   0, 0, 0, F, 1, 1, 1, 0, 0,  32'h220, 32'h0},   // R9 pop 5
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 1, 5,  32'h200, 32'h20},  // R8 retake 5
        '{32'h0,   0, 0, 0, F, 1, 1, 1, 0, 0,  32'h200, 32'h0},   // R9
        '{32'h0,   0, 0, 0, F, 0, 1, 0, 0, 0,  32'h200, 32'h0},   // R3 global off
        '{32'h0,   0, 0, 0, 32'hFFFF_FDFF, 1, 1, 0, 0, 0, 32'h200, 32'h0}, // R3 masked
        '{32'h0, 32'h4000_0000, 0, 0, F, 1, 1, 0, 1, 9, 32'h4000_0000, 32'h200}, // R2 R5
        '{32'h0,   0, 0, 0, F, 1, 0, 0, 0, 0,  32'h4000_0000, 32'h200}, // R7
        '{32'h2,   0, 0, 0, F, 1, 0, 0, 0, 0,  32'h4000_0002, 32'h200}, // R7
        '{32'h0,   0, 0, 0, F, 1, 0, 1, 0, 0,  32'h4000_0002, 32'h0},   // R9
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 1, 1,  32'h4000_0000, 32'h2},   // R4
        '{32'h0,   0, 0, 0, F, 1, 1, 1, 0, 0,  32'h4000_0000, 32'h0},   // R9
        '{32'h0,   0, 1, 32'h9000_0000, F, 1, 1, 0, 1, 30, 32'h9000_0000, 32'h4000_0000}, // R2
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 1, 28, 32'h8000_0000, 32'h5000_0000}, // R6
        '{32'h0,   0, 0, 0, F, 1, 1, 1, 0, 0,  32'h8000_0000, 32'h4000_0000}, // R9
        '{32'h0,   0, 0, 0, F, 1, 1, 1, 0, 0,  32'h8000_0000, 32'h0},   // R9
        '{32'h0,   0, 0, 0, F, 1, 1, 0, 1, 31, 32'h0,   32'h8000_0000}, // R4
        '{32'h0,   0, 0, 0, F, 1, 1, 1, 0, 0,  32'h0,   32'h0}          // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [31:0] hw, input logic [31:0] sd, input logic wr,
                       input logic [31:0] wd, input logic [31:0] m, input logic ge,
                       input logic ne, input logic r);
        @(negedge clk);
        irq_in       = hw;
        lat_set_en   = (sd != 0);
        lat_set_data = sd;
        lat_wr_en    = wr;
        lat_wr_data  = wd;
        mask_in      = m;
        glob_en      = ge;
        nest_en      = ne;
        rti          = r;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R11 latch", latch_o, 0);
        chk("R11 active", active_o, 0);
        chk("R11 pmask", pmask_o, 0);
        chk("R11 vec", {vec_ack[26:0], vec_valid, vec_idx}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < ROWS; k++) begin
            cyc(TBL[k].hw, TBL[k].setd, TBL[k].wr, TBL[k].wrd, TBL[k].msk,
                TBL[k].ge, TBL[k].ne, TBL[k].rt);
            chk($sformatf("R4 row%0d valid", k), 32'(vec_valid), 32'(TBL[k].ev));
            if (TBL[k].ev) begin
                chk($sformatf("R4 row%0d idx", k), 32'(vec_idx), 32'(TBL[k].ei));
                chk($sformatf("R4 row%0d ack", k), vec_ack, 32'h1 << TBL[k].ei);
            end
            chk($sformatf("R5 row%0d latch", k), latch_o, TBL[k].elat);
            chk($sformatf("R5 row%0d active", k), active_o, TBL[k].eact);
        end

        // R10: temporary mask follows active state with nesting off
        cyc(32'h20, 0, 0, 0, F, 1, 0, 0);
        cyc(0, 0, 0, 0, F, 1, 0, 0);
        chk("R10 take idx", 32'(vec_idx), 5);
        chk("R10 pmask nest off", pmask_o, 32'h1F);
        cyc(0, 0, 0, 0, F, 1, 0, 1);
        chk("R10 pmask idle", pmask_o, F);
        chk("R9 no vec on rti", 32'(vec_valid), 0);

        // R9: return with nothing active
        cyc(0, 0, 0, 0, F, 1, 1, 1);
        chk("R9 empty rti active", active_o, 0);
        chk("R9 empty rti latch", latch_o, 0);

        // R9: eligible request waits out a return cycle
        cyc(32'h20, 0, 0, 0, F, 1, 1, 0);
        cyc(0, 0, 0, 0, F, 1, 1, 0);
        cyc(32'h4, 0, 0, 0, F, 1, 1, 0);
        chk("R6 latch 2", latch_o, 32'h4);
        cyc(0, 0, 0, 0, F, 1, 1, 1);
        chk("R9 rti blocks vec", 32'(vec_valid), 0);
        chk("R9 rti active", active_o, 0);
        chk("R9 rti latch kept", latch_o, 32'h4);
        cyc(0, 0, 0, 0, F, 1, 1, 0);
        chk("R9 after rti idx", 32'({vec_valid, vec_idx}), 32'h22);
        cyc(0, 0, 0, 0, F, 1, 1, 1);

        // R2: full write with set and hardware request ORed on top
        cyc(32'h1, 32'h2000_0000, 1, 32'h1000_0000, F, 0, 1, 0);
        chk("R2 combined write", latch_o, 32'h3000_0001);
        cyc(0, 0, 1, 0, F, 0, 1, 0);
        chk("R2 write clears", latch_o, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule